// File: doc/BRIEF.md
# Flash Two-Byte Word Write Command Front End

This block is the command front end of a byte-wide flash device. It watches single-cycle bus write strobes that carry an address and a data byte. It decodes command codes from them and runs a two-step sequence that builds a 16-bit word from two byte writes. When the word is complete, it starts a timed internal program operation. A small register array with a fixed program delay stands in for the memory cells.

A host starts a word write by writing the start code at any address. It then writes the two bytes. The least significant address bit of the first byte write picks which half of the word that byte fills. The second byte always fills the other half, whatever that address bit holds.

The host reads a status byte. It shows whether the program engine is ready and whether a sequence error has been latched. The status byte is captured again only when a read begins, that is, when chip enable and output enable both become active. A separate command switches reads back to the array contents.

Top module: `flash_wr_cui`

## Requirements
- R1: After reset, reads return array contents, every array word is 0000h, and the status byte is 80h (ready, no error).
- R2: A write of FBh at any address while idle switches reads to the status byte. If the engine is ready and no error is latched, the write also begins a word-write sequence.
- R3: In the first data write of a sequence, address bit 0 selects the half of the word: 0 fills bits 7..0 and 1 fills bits 15..8. Address bits above bit 0 give the word address.
- R4: The second data write fills the other half of the word. The bit 0 it carries has no effect.
- R5: From the clock edge that accepts the second data write, status bit 7 reads 0 for exactly PROG_CYC cycles. The word is then stored in the array and bit 7 returns to 1.
- R6: An FBh write while a program is in progress sets status bits 5 and 4. The program in progress still completes and stores its word.
- R7: A second data write whose word address differs from the first one sets bits 5 and 4 and abandons the sequence. No array word changes.
- R8: Bits 5 and 4 are cleared only by a write of 50h while idle. That write also selects status reads. While they are set, an FBh write starts no sequence, and later non-command writes leave the array unchanged. An FFh write does not clear them.
- R9: A write of FFh while idle switches reads to array contents. In array mode, address bit 0 selects the byte returned: 0 gives the low byte and 1 gives the high byte of the addressed word.
- R10: In status mode, the value read is captured when a read begins. A read held active does not follow later status changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Byte address; bit 0 is the byte select |
| bus_wdata | input | 8 | Write data or command code |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | 8 | Status snapshot or array byte |

## Verification
The bench sweeps every word address with both first-byte selects. It also flips the host's byte-select bit on the second write. A design that honoured that bit, or placed a byte in the wrong half, would read back swapped or doubled bytes.

The busy window is sampled one cycle before and one cycle after its expected end. A timer that is off by one fails on one side of that pair.

Several error paths are driven: a restart while busy, a word-address mismatch, and a retry while an error is still latched. After each, the bench confirms that the status shows 30h or B0h and that no array word moved. A design that cleared the error on FFh, or started the refused sequence, would show a clean status or corrupted words.

A read held across the end of a program must keep its busy snapshot. A design that tracked status continuously would show the ready bit too early.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;
  localparam logic [7:0] CMD_WORD_WR  = 8'hFB;
  localparam logic [7:0] CMD_READ_ARR = 8'hFF;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_FIRST  = 2'd1,
    SEQ_SECOND = 2'd2
  } seq_t;
endpackage

// File: rtl/cui_seq.sv
module cui_seq
  import flash_cui_pkg::*;
#(
  parameter int AW = 5,
  localparam int WA_W = AW - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic            busy,
  output logic            start,
  output logic [WA_W-1:0] prog_addr,
  output logic [15:0]     prog_word,
  output logic            err,
  output logic            show_stat
);
  seq_t            state_q, state_n;
  logic [15:0]     data_q, data_n;
  logic [WA_W-1:0] word_q, word_n;
  logic            sel_q, sel_n;
  logic            err_q, err_n;
  logic            stat_q, stat_n;
  logic            start_n;
  logic            clr_cmd;

  assign clr_cmd = wr_stb && (state_q == SEQ_IDLE) && (wr_data == CMD_CLR_STAT);

  always_comb begin
    state_n = state_q;
    data_n  = data_q;
    word_n  = word_q;
    sel_n   = sel_q;
    err_n   = err_q;
    stat_n  = stat_q;
    start_n = 1'b0;
    if (wr_stb) begin
      case (state_q)
        SEQ_IDLE: begin
          if (wr_data == CMD_WORD_WR) begin
            stat_n = 1'b1;
            if (busy) err_n = 1'b1;
            else if (!err_q) state_n = SEQ_FIRST;
          end else if (wr_data == CMD_READ_ARR) begin
            stat_n = 1'b0;
          end else if (wr_data == CMD_CLR_STAT) begin
            err_n  = 1'b0;
            stat_n = 1'b1;
          end
        end
        SEQ_FIRST: begin
          word_n = wr_addr[AW-1:1];
          sel_n  = wr_addr[0];
          if (wr_addr[0]) data_n[15:8] = wr_data;
          else            data_n[7:0]  = wr_data;
          state_n = SEQ_SECOND;
        end
        SEQ_SECOND: begin
          state_n = SEQ_IDLE;
          if (wr_addr[AW-1:1] != word_q) begin
            err_n = 1'b1;
          end else begin
            start_n = 1'b1;
            if (sel_q) data_n[7:0]  = wr_data;
            else       data_n[15:8] = wr_data;
          end
        end
        default: state_n = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      data_q  <= '0;
      word_q  <= '0;
      sel_q   <= 1'b0;
      err_q   <= 1'b0;
      stat_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      data_q  <= data_n;
      word_q  <= word_n;
      sel_q   <= sel_n;
      err_q   <= err_n;
      stat_q  <= stat_n;
    end
  end

  assign start     = start_n;
  assign prog_addr = word_q;
  assign prog_word = data_n;
  assign err       = err_q;
  assign show_stat = stat_q;

  // R8: error bits survive every cycle that carries no clear command
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !clr_cmd |=> err_q);

  // R6: a sequence can be open only while the engine is idle
  p_seq_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SEQ_IDLE) |-> !busy);
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int PROG_CYC = 8,
  parameter int WA_W = 4,
  localparam int CW = $clog2(PROG_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [WA_W-1:0] addr,
  input  logic [15:0]     word,
  output logic            busy,
  output logic            wr_en,
  output logic [WA_W-1:0] wr_addr,
  output logic [15:0]     wr_word
);
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [WA_W-1:0] addr_q, addr_n;
  logic [15:0]     word_q, word_n;

  always_comb begin
    cnt_n  = cnt_q;
    addr_n = addr_q;
    word_n = word_q;
    if (start) begin
      cnt_n  = CW'(PROG_CYC);
      addr_n = addr;
      word_n = word;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
      word_q <= '0;
    end else begin
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
      word_q <= word_n;
    end
  end

  assign busy    = (cnt_q != '0);
  assign wr_en   = (cnt_q == CW'(1));
  assign wr_addr = addr_q;
  assign wr_word = word_q;

  // R5: a running program counts down one step per cycle
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R6: the sequencer never launches a program over a running one
  p_start_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cnt_q == '0));
endmodule

// File: rtl/word_array.sv
module word_array #(
  parameter int WA_W = 4,
  localparam int DEPTH = 1 << WA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [WA_W-1:0] wr_addr,
  input  logic [15:0]     wr_word,
  input  logic [WA_W-1:0] rd_addr,
  output logic [15:0]     rd_word
);
  logic [15:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [15:0] cell_q;
    logic        hit;
    assign hit = wr_en && (wr_addr == WA_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cell_q <= '0;
      else if (hit) cell_q <= wr_word;
    end
    assign words[i] = cell_q;
  end

  assign rd_word = words[rd_addr];
endmodule

// File: rtl/flash_wr_cui.sv
module flash_wr_cui #(
  parameter int ADDR_W   = 5,
  parameter int PROG_CYC = 8,
  localparam int WA_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              ce_n,
  input  logic              oe_n,
  output logic [7:0]        rd_data
);
  logic [1:0]      rst_sync_q;
  logic            rst_i_n;
  logic            start, busy, err, show_stat, wr_en;
  logic [WA_W-1:0] prog_addr, wr_addr;
  logic [15:0]     prog_word, wr_word, rd_word;
  logic [7:0]      status;
  logic            rd_act, rd_act_q;
  logic [7:0]      snap_q, snap_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  cui_seq #(.AW(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_i_n), .wr_stb(bus_we), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .busy(busy), .start(start), .prog_addr(prog_addr),
    .prog_word(prog_word), .err(err), .show_stat(show_stat)
  );

  prog_timer #(.PROG_CYC(PROG_CYC), .WA_W(WA_W)) tmr_i (
    .clk(clk), .rst_n(rst_i_n), .start(start), .addr(prog_addr),
    .word(prog_word), .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_word(wr_word)
  );

  word_array #(.WA_W(WA_W)) arr_i (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_word(wr_word), .rd_addr(bus_addr[ADDR_W-1:1]), .rd_word(rd_word)
  );

  assign status = {~busy, 1'b0, err, err, 4'b0000};
  assign rd_act = ~ce_n & ~oe_n;

  always_comb begin
    snap_n = snap_q;
    if (rd_act && !rd_act_q) snap_n = status;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rd_act_q <= 1'b0;
      snap_q   <= 8'h80;
    end else begin
      rd_act_q <= rd_act;
      snap_q   <= snap_n;
    end
  end

  assign rd_data = show_stat ? snap_q
                 : (bus_addr[0] ? rd_word[15:8] : rd_word[7:0]);

  // R10: a held read keeps its captured status
  p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_act && rd_act_q |=> $stable(snap_q));
endmodule

// File: tb/flash_wr_cui_tb_top.sv
module flash_wr_cui_tb_top;
  localparam int AW = 5;
  localparam int PC = 8;
  localparam int NW = 1 << (AW - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [7:0]    rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] exp_mem [NW];

  flash_wr_cui #(.ADDR_W(AW), .PROG_CYC(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ce_n(ce_n), .oe_n(oe_n), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic bwr(input logic [AW-1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic brd(input logic [AW-1:0] a, output logic [7:0] v);
    bus_addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(posedge clk); @(negedge clk);
    v = rd_data;
    ce_n = 1'b1; oe_n = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk_word(input string tag, input int w);
    logic [7:0] v;
    brd(AW'(w * 2), v);     chk(tag, v, exp_mem[w][7:0]);
    brd(AW'(w * 2 + 1), v); chk(tag, v, exp_mem[w][15:8]);
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] d1, d2;
    for (int w = 0; w < NW; w++) exp_mem[w] = 16'h0000;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1: reset state, array mode, zero contents
    brd(AW'(6), v);  chk("R1 array zero", v, 8'h00);
    brd(AW'(31), v); chk("R1 array zero", v, 8'h00);

    // Sweep: every word, both first-byte selects (R2, R3, R4, R5, R9)
    for (int w = 0; w < NW; w++) begin
      for (int s = 0; s < 2; s++) begin
        d1 = 8'((w * 16 + s * 5 + 3) & 255);
        d2 = 8'(~((w * 7 + s * 9) & 255));
        bwr(AW'(w * 2 + 1), 8'hFB);
        brd(AW'(0), v); chk("R1 R2 status ready", v, 8'h80);
        bwr(AW'(w * 2 + s), d1);
        bwr(AW'(w * 2 + (w & 1)), d2);   // R4: host bit 0 varies
        exp_mem[w] = (s == 0) ? {d2, d1} : {d1, d2};
        if (s == 0) begin
          cyc(PC - 1);
          brd(AW'(0), v); chk("R5 busy at last cycle", v, 8'h00);
        end else begin
          cyc(PC);
          brd(AW'(0), v); chk("R5 ready after window", v, 8'h80);
        end
        bwr(AW'(0), 8'hFF);
        chk_word("R3 R4 R9 word readback", w);
      end
    end

    // R10: a held read keeps the busy snapshot
    bwr(AW'(0), 8'hFB);
    bwr(AW'(4), 8'h11);
    bwr(AW'(5), 8'h22);
    exp_mem[2] = 16'h2211;
    bus_addr = '0; ce_n = 1'b0; oe_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10 snapshot busy", rd_data, 8'h00);
    cyc(PC + 2);
    chk("R10 held read unchanged", rd_data, 8'h00);
    oe_n = 1'b1;
    @(posedge clk); @(negedge clk);
    oe_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10 toggle refreshes", rd_data, 8'h80);
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(1);

    // R6: restart while busy
    bwr(AW'(0), 8'hFB);
    bwr(AW'(6), 8'hAA);
    bwr(AW'(6), 8'hBB);
    exp_mem[3] = 16'hBBAA;
    bwr(AW'(0), 8'hFB);
    brd(AW'(0), v); chk("R6 error while busy", v, 8'h30);
    cyc(PC);
    brd(AW'(0), v); chk("R6 error kept, ready", v, 8'hB0);
    bwr(AW'(0), 8'hFF);
    chk_word("R6 pending word stored", 3);

    // R8: retry refused while error latched, FFh does not clear
    bwr(AW'(0), 8'hFB);
    bwr(AW'(8), 8'h12);
    bwr(AW'(9), 8'h34);
    cyc(PC + 1);
    brd(AW'(0), v); chk("R8 no program started", v, 8'hB0);
    bwr(AW'(0), 8'hFF);
    chk_word("R8 array unchanged", 4);
    bwr(AW'(0), 8'hFB);
    brd(AW'(0), v); chk("R8 FFh kept error", v, 8'hB0);
    bwr(AW'(0), 8'h50);
    brd(AW'(0), v); chk("R8 clear", v, 8'h80);

    // R7: word address mismatch on the second write
    bwr(AW'(0), 8'hFB);
    bwr(AW'(7), 8'h5A);
    bwr(AW'(10), 8'hA5);
    cyc(1);
    brd(AW'(0), v); chk("R7 mismatch error", v, 8'hB0);
    bwr(AW'(0), 8'hFF);
    chk_word("R7 word 3 unchanged", 3);
    chk_word("R7 word 5 unchanged", 5);
    bwr(AW'(0), 8'h50);
    brd(AW'(0), v); chk("R7 R8 cleared", v, 8'h80);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule